// File: doc/BRIEF.md
# Discrete Input Serial Port Controller

This block is the digital side of an eight-channel discrete input sensor. Each channel level reaches it as a bit that has already been digitized, and the block returns a per-channel mode setting as a set of mode-select outputs. A host talks to it over an SPI-style slave port with five signals: an active-low chip select, a serial clock, a serial data input, a three-state serial data output, and a register-select pin.

Two registers sit behind the one port. The first is a snapshot register that takes all channel levels in parallel when chip select falls. The second is a configuration shift register that feeds an output latch when chip select rises. Both registers shift MSB first out of the serial output. The bits taken in on the serial input appear again on the serial output eight clocks later, so several devices can be chained. During a configuration write the current setting shifts out while the new one shifts in.

All port signals are sampled by the system clock `clk`. Edges of chip select and of the serial clock are found by comparing each sample with the one before it.

Top module: `dsi_discrete_port`

## Requirements
- R1: `sel` is sampled when chip select falls. A value of 1 addresses the snapshot register and 0 addresses the configuration register. The choice holds for the whole transfer, and changes of `sel` while chip select is low have no effect.
- R2: While `cs_n` is high, `sdo_oe` is 0 and edges on `sclk` change neither register.
- R3: When chip select falls with the snapshot register addressed, bit i of that register takes `din[i]`. A low level gives 0 and a high level gives 1. Later changes of `din` during the transfer do not alter what is read out.
- R4: While `cs_n` is low, `sdo_oe` is 1 and `sdo` shows bit 7 of the addressed register. On each rising `sclk` edge, `sdi` enters bit 0 and bit n moves to bit n+1.
- R5: In a 16-clock transfer, the first 8 bits come from the register and the next 8 bits are the first 8 `sdi` bits. For a configuration write, the last 8 `sdi` bits remain in the register.
- R6: `cfg_out` changes only when chip select rises after a configuration transfer. It then takes the configuration shift register. It stays unchanged throughout every transfer and after every snapshot transfer.
- R7: A configuration transfer shifts out the present setting, MSB first, while the new bits shift in.
- R8: Synchronous reset `rst` clears the configuration shift register and `cfg_out` to all zeros. A `cfg_out` bit of 1 selects pull-up (ground/open) mode for its channel and 0 selects pull-down (28V/open) mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all port signals |
| rst | input | 1 | Synchronous active-high reset, stands in for power-on reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock; shifting happens on its rising edge |
| sel | input | 1 | Register select: 1 = snapshot, 0 = configuration |
| sdi | input | 1 | Serial data in, enters bit 0 |
| din | input | NCH | Digitized channel levels |
| sdo | output | 1 | Serial data out, bit 7 of the addressed register |
| sdo_oe | output | 1 | Output enable for the three-state serial output |
| cfg_out | output | NCH | Latched per-channel mode selects |

## Verification
The assertions assume that `sclk`, `cs_n`, `sel` and `sdi` change no faster than once per `clk` period, so that each edge appears in the samples. They also assume that chip select stays low for at least one cycle before the first rising serial clock edge. The stimulus drives every port signal on the falling edge of `clk`. It holds each `sclk` level for a full `clk` period, and it inserts an idle cycle after chip select falls and before it rises. Within those limits, the sweeps cover every snapshot value and every configuration value, both eight- and sixteen-clock transfers, `sel` and `din` changing during a transfer, and serial clock pulses while chip select is high.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

    localparam int NCH_DEFAULT = 8;

    typedef enum logic {
        SEL_CFG  = 1'b0,
        SEL_SNAP = 1'b1
    } regsel_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic shift_pulse;
        logic selected;
    } spi_evt_t;

    function automatic logic pick_out(input regsel_e s, input logic snap_msb, input logic cfg_msb);
        return (s == SEL_SNAP) ? snap_msb : cfg_msb;
    endfunction

endpackage

// File: rtl/dsi_edge_detect.sv
module dsi_edge_detect
    import dsi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    output spi_evt_t evt
);

    logic csn_q;
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            csn_q <= cs_n;
            sck_q <= sclk;
        end
    end

    always_comb begin
        evt.cs_fall     = !cs_n && csn_q;
        evt.cs_rise     = cs_n && !csn_q;
        evt.shift_pulse = sclk && !sck_q && !cs_n && !csn_q;
        evt.selected    = !cs_n;
    end

    AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !evt.shift_pulse) else $error("shift while deselected"); // R2

endmodule

// File: rtl/dsi_shift_reg.sv
module dsi_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] pdin,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    logic [W-1:0] shifted;

    generate
        for (genvar i = 0; i < W; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign shifted[i] = sin;
            end else begin : g_body
                assign shifted[i] = q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= pdin;
        end else if (shift) begin
            q <= shifted;
        end
    end

    AST_PARALLEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(pdin)) else $error("parallel load lost"); // R3
    AST_SERIAL_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> q[0] == $past(sin)) else $error("serial entry lost"); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!shift && !load) |=> $stable(q)) else $error("register moved while idle"); // R2

endmodule

// File: rtl/dsi_cfg_latch.sv
module dsi_cfg_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (commit) begin
            q <= d;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> q == '0) else $error("latch not cleared"); // R8
    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(q)) else $error("latch moved without commit"); // R6

endmodule

// File: rtl/dsi_discrete_port.sv
module dsi_discrete_port
    import dsi_pkg::*;
#(
    parameter int NCH = NCH_DEFAULT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic           sel,
    input  logic           sdi,
    input  logic [NCH-1:0] din,
    output logic           sdo,
    output logic           sdo_oe,
    output logic [NCH-1:0] cfg_out
);

    localparam int MSB = NCH - 1;

    spi_evt_t       evt;
    regsel_e        sel_q;
    logic [NCH-1:0] snap_q;
    logic [NCH-1:0] cfg_q;
    logic           snap_load;
    logic           snap_shift;
    logic           cfg_shift;
    logic           cfg_commit;

    dsi_edge_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .evt  (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_CFG;
        end else if (evt.cs_fall) begin
            sel_q <= regsel_e'(sel);
        end
    end

    always_comb begin
        snap_load  = evt.cs_fall && (sel == SEL_SNAP);
        snap_shift = evt.shift_pulse && (sel_q == SEL_SNAP);
        cfg_shift  = evt.shift_pulse && (sel_q == SEL_CFG);
        cfg_commit = evt.cs_rise && (sel_q == SEL_CFG);
    end

    dsi_shift_reg #(.W(NCH)) u_snap (
        .clk   (clk),
        .rst   (rst),
        .load  (snap_load),
        .pdin  (din),
        .shift (snap_shift),
        .sin   (sdi),
        .q     (snap_q)
    );

    dsi_shift_reg #(.W(NCH)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (1'b0),
        .pdin  ('0),
        .shift (cfg_shift),
        .sin   (sdi),
        .q     (cfg_q)
    );

    dsi_cfg_latch #(.W(NCH)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .commit (cfg_commit),
        .d      (cfg_q),
        .q      (cfg_out)
    );

    assign sdo    = pick_out(sel_q, snap_q[MSB], cfg_q[MSB]);
    assign sdo_oe = evt.selected;

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n)) |=> $stable(sel_q)) else $error("select moved mid-transfer"); // R1
    AST_CFG_STABLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> $stable(cfg_out)) else $error("cfg_out moved during transfer"); // R6
    AST_CFG_SR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |=> $stable(cfg_q)) else $error("config register moved while idle"); // R2

endmodule

// File: tb/tb_dsi_discrete_port.sv
module tb_dsi_discrete_port;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cs_n = 1'b1;
    logic           sclk = 1'b0;
    logic           sel = 1'b0;
    logic           sdi = 1'b0;
    logic [NCH-1:0] din = '0;
    logic           sdo;
    logic           sdo_oe;
    logic [NCH-1:0] cfg_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    dsi_discrete_port #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sel(sel),
        .sdi(sdi), .din(din), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_out(cfg_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // flip: bit index at which sel and din are inverted mid-transfer (-1 = never)
    task automatic xfer(input logic s, input logic [15:0] tx, input int nb, input int flip,
                        output logic [15:0] rx, output logic [NCH-1:0] cfg_before);
        @(negedge clk);
        sel = s; cs_n = 1'b0;
        @(negedge clk);
        rx = '0;
        rx[nb-1] = sdo;
        chk("R4 oe while selected", {15'd0, sdo_oe}, 16'd1);
        for (int i = 0; i < nb; i++) begin
            if (i == flip) begin
                sel = ~sel; din = ~din;
            end
            sdi = tx[nb-1-i];
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
            if (i < nb-1) rx[nb-2-i] = sdo;
            @(negedge clk);
        end
        cfg_before = cfg_out;
        cs_n = 1'b1;
        @(negedge clk);
        chk("R2 oe when deselected", {15'd0, sdo_oe}, 16'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0]    rx;
        logic [NCH-1:0] cb;
        logic [NCH-1:0] prev;
        logic [15:0]    tx;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset cfg_out", {8'd0, cfg_out}, 16'd0);
        chk("R2 reset oe", {15'd0, sdo_oe}, 16'd0);

        // R3 R4: every snapshot value read out MSB first
        for (int v = 0; v < 256; v++) begin
            din = v[7:0];
            xfer(1'b1, 16'h0000, 8, -1, rx, cb);
            chk("R3 snapshot read", rx, {8'd0, v[7:0]});
        end
        chk("R6 snapshot leaves cfg_out", {8'd0, cfg_out}, 16'd0);

        // R7 R6: every config value, readback of present setting
        prev = '0;
        for (int v = 0; v < 256; v++) begin
            tx = {8'd0, 8'(v * 37 + 11)};
            xfer(1'b0, tx, 8, -1, rx, cb);
            chk("R7 config readback", rx, {8'd0, prev});
            chk("R6 cfg_out held in transfer", {8'd0, cb}, {8'd0, prev});
            chk("R6 cfg_out committed", {8'd0, cfg_out}, tx);
            prev = tx[7:0];
        end

        // R5 snapshot daisy chain
        for (int v = 0; v < 16; v++) begin
            din = 8'(v * 29 + 3);
            tx = 16'(v * 4099 + 777);
            xfer(1'b1, tx, 16, -1, rx, cb);
            chk("R5 snapshot chain", rx, {din, tx[15:8]});
        end
        chk("R6 cfg_out after chain reads", {8'd0, cfg_out}, {8'd0, prev});

        // R5 config daisy chain
        for (int v = 0; v < 16; v++) begin
            tx = 16'(v * 5003 + 91);
            xfer(1'b0, tx, 16, -1, rx, cb);
            chk("R5 config chain out", rx, {prev, tx[15:8]});
            chk("R5 config chain latch", {8'd0, cfg_out}, {8'd0, tx[7:0]});
            prev = tx[7:0];
        end

        // R2 sclk pulses while deselected are ignored
        xfer(1'b0, 16'h00A6, 8, -1, rx, cb);
        prev = 8'hA6;
        sdi = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
        end
        chk("R2 cfg_out after idle clocks", {8'd0, cfg_out}, 16'h00A6);
        xfer(1'b0, 16'h00A6, 8, -1, rx, cb);
        chk("R2 config unchanged by idle clocks", rx, 16'h00A6);

        // R1 R3 sel and din flipped mid snapshot transfer
        din = 8'h6D;
        xfer(1'b1, 16'h0000, 8, 3, rx, cb);
        chk("R1 R3 snapshot despite flips", rx, 16'h006D);
        chk("R1 no commit after snapshot", {8'd0, cfg_out}, 16'h00A6);

        // R1 sel flipped mid config transfer
        xfer(1'b0, 16'h003B, 8, 2, rx, cb);
        chk("R1 config readback despite flip", rx, 16'h00A6);
        chk("R1 config committed despite flip", {8'd0, cfg_out}, 16'h003B);

        // R8 reset after configuration
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R8 cfg_out cleared", {8'd0, cfg_out}, 16'd0);
        xfer(1'b0, 16'h0000, 8, -1, rx, cb);
        chk("R8 config register cleared", rx, 16'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule